// File: doc/BRIEF.md
# LCD Multiplex Row Bank Selector

This block is the read path between a segment display memory and the segment drivers of a multiplexed LCD controller. The memory is held outside the block and given to it as a flat image of four rows by `NUM_COLS` columns. On every multiplex phase tick the block advances a logical phase counter through the scan sequence of the configured drive mode. It maps that phase to a physical memory row. It then registers that row of every column as the segment vector, together with the physical row index and a one-hot backplane vector that marks the logical phase.

In the static and 1:2 modes an output bank setting can move the displayed rows from the lower pair (0, 1) to the upper pair (2, 3). Software can then fill one pair through a separate write path while the other pair stays on the glass. The block samples drive mode and output bank only at the tick that starts a new frame, so a frame is never built from two configurations.

Top module: `lcdm_row_bank_sel`

## Requirements
- R1: While `rst_n` is low, and until the first phase tick after it, `row_idx` is 0, `bp_onehot` is 0000 and `seg_data` is all zeros. The first tick after reset always starts a new frame at phase 0.
- R2: The `mode_sel` encoding is 0 static, 1 two-phase, 2 three-phase, 3 four-phase. In four-phase mode successive ticks give phases 0, 1, 2, 3, 0, and so on.
- R3: In three-phase mode successive ticks give phases 0, 1, 2, 0, and so on, with physical rows 0, 1, 2, whatever the output bank is.
- R4: In two-phase mode with output bank 0, successive ticks give phases 0, 1, 0, and so on, on rows 0 and 1.
- R5: In static mode every tick gives phase 0, and `bp_onehot` stays 0001.
- R6: With output bank 1, static mode shows row 2 and two-phase mode shows rows 2 and 3 at phases 0 and 1. In three-phase and four-phase modes the bank has no effect.
- R7: `mode_sel` and `out_bank` are sampled only at a tick that ends the last phase of the current frame (or the first tick after reset). A change made mid-frame has no effect on the rest of that frame.
- R8: Bit `mem_image[r*NUM_COLS + c]` is column c of row r. At the clock edge where `phase_tick` is high, `seg_data[c]` takes column c of the selected row, as `mem_image` holds it in that cycle.
- R9: In cycles without a tick, `row_idx`, `bp_onehot` and `seg_data` hold their values, even when `mem_image` changes.
- R10: `bp_onehot` has bit p set for logical phase p, and `row_idx` gives the physical row, so the two differ by 2 when bank 1 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_tick | input | 1 | One-cycle pulse that advances the multiplex phase |
| mode_sel | input | 2 | Requested drive mode (0 static, 1 two-phase, 2 three-phase, 3 four-phase) |
| out_bank | input | 1 | Requested output bank (1 selects the upper rows in static and two-phase modes) |
| mem_image | input | 4*NUM_COLS | Display memory image, row-major |
| row_idx | output | 2 | Physical row currently presented |
| bp_onehot | output | 4 | One-hot logical phase (backplane select) |
| seg_data | output | NUM_COLS | Selected row of all columns |

## Verification
Two functions can land on the same clock edge: the tick that closes a frame must wrap the phase to 0 and also latch a new mode and bank. The next row is then mapped from the newly latched values. The vector table changes mode and bank exactly on those wrap ticks, including a move from static straight into four-phase and bank swaps in two-phase mode, and checks that the row at phase 0 already reflects the new setting. It also changes mode and bank on mid-frame ticks and checks that the running sequence is unchanged until the next wrap.

// File: rtl/lcdm_pkg.sv
`timescale 1ns/1ps
package lcdm_pkg;

   typedef enum logic [1:0] {
      MODE_STATIC = 2'd0,
      MODE_MUX2   = 2'd1,
      MODE_MUX3   = 2'd2,
      MODE_MUX4   = 2'd3
   } drive_mode_e;

   // highest logical phase reached in a frame of the given mode
   function automatic logic [1:0] last_phase(input drive_mode_e m);
      case (m)
         MODE_STATIC: return 2'd0;
         MODE_MUX2:   return 2'd1;
         MODE_MUX3:   return 2'd2;
         default:     return 2'd3;
      endcase
   endfunction

   // modes in which the output bank may swap in the upper row pair
   function automatic logic bank_capable(input drive_mode_e m);
      return (m == MODE_STATIC) || (m == MODE_MUX2);
   endfunction

endpackage

// File: rtl/lcdm_phase_seq.sv
`timescale 1ns/1ps
module lcdm_phase_seq
   import lcdm_pkg::*;
#(
   parameter int unsigned PHASE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  drive_mode_e        mode_req,
   input  logic               bank_req,
   output logic [PHASE_W-1:0] phase_nxt,
   output drive_mode_e        mode_nxt,
   output logic               bank_nxt
);

   logic [PHASE_W-1:0] phase_q;
   drive_mode_e        mode_q;
   logic               bank_q;
   logic               at_last;
   logic               frame_start;

   always_comb begin
      at_last     = (phase_q == PHASE_W'(last_phase(mode_q)));
      frame_start = tick && at_last;
      mode_nxt    = frame_start ? mode_req : mode_q;
      bank_nxt    = frame_start ? bank_req : bank_q;
      if (!tick)
         phase_nxt = phase_q;
      else if (at_last)
         phase_nxt = '0;
      else
         phase_nxt = phase_q + PHASE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         mode_q  <= MODE_STATIC;
         bank_q  <= 1'b0;
      end else if (tick) begin
         phase_q <= phase_nxt;
         mode_q  <= mode_nxt;
         bank_q  <= bank_nxt;
      end
   end

endmodule

// File: rtl/lcdm_row_map.sv
`timescale 1ns/1ps
module lcdm_row_map
   import lcdm_pkg::*;
#(
   parameter int unsigned ROW_W     = 2,
   parameter bit          BANK_SWAP = 1'b1
) (
   input  logic [ROW_W-1:0] phase,
   input  drive_mode_e      mode,
   input  logic             bank,
   output logic [ROW_W-1:0] row
);

   localparam logic [ROW_W-1:0] UPPER_OFS = ROW_W'(1) << (ROW_W - 1);

   generate
      if (BANK_SWAP) begin : g_swap
         always_comb begin
            row = phase;
            if (bank && bank_capable(mode))
               row = phase | UPPER_OFS;
         end
      end else begin : g_plain
         logic unused_cfg;
         assign unused_cfg = bank ^ (^mode);
         assign row = phase;
      end
   endgenerate

endmodule

// File: rtl/lcdm_col_mux.sv
`timescale 1ns/1ps
module lcdm_col_mux #(
   parameter int unsigned NUM_COLS = 40,
   parameter int unsigned NUM_ROWS = 4,
   localparam int unsigned ROW_W   = $clog2(NUM_ROWS),
   localparam int unsigned MEM_W   = NUM_COLS * NUM_ROWS
) (
   input  logic [MEM_W-1:0]    mem_image,
   input  logic [ROW_W-1:0]    row,
   output logic [NUM_COLS-1:0] seg
);

   genvar c, r;
   generate
      for (c = 0; c < NUM_COLS; c++) begin : g_col
         logic [NUM_ROWS-1:0] col_bits;
         for (r = 0; r < NUM_ROWS; r++) begin : g_row
            assign col_bits[r] = mem_image[r*NUM_COLS + c];
         end
         assign seg[c] = col_bits[row];
      end
   endgenerate

endmodule

// File: rtl/lcdm_row_bank_sel.sv
`timescale 1ns/1ps
module lcdm_row_bank_sel
   import lcdm_pkg::*;
#(
   parameter int unsigned NUM_COLS  = 40,
   parameter int unsigned NUM_ROWS  = 4,
   parameter bit          BANK_SWAP = 1'b1,
   localparam int unsigned ROW_W    = $clog2(NUM_ROWS),
   localparam int unsigned MEM_W    = NUM_COLS * NUM_ROWS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                phase_tick,
   input  logic [1:0]          mode_sel,
   input  logic                out_bank,
   input  logic [MEM_W-1:0]    mem_image,
   output logic [ROW_W-1:0]    row_idx,
   output logic [NUM_ROWS-1:0] bp_onehot,
   output logic [NUM_COLS-1:0] seg_data
);

   generate
      if (NUM_ROWS != 4) begin : g_bad_rows
         $error("lcdm_row_bank_sel: NUM_ROWS must be 4");
      end
      if (NUM_COLS < 1) begin : g_bad_cols
         $error("lcdm_row_bank_sel: NUM_COLS must be at least 1");
      end
   endgenerate

   logic [ROW_W-1:0]    phase_nxt;
   drive_mode_e         mode_nxt;
   logic                bank_nxt;
   logic [ROW_W-1:0]    row_nxt;
   logic [NUM_COLS-1:0] seg_nxt;

   lcdm_phase_seq #(
      .PHASE_W (ROW_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (phase_tick),
      .mode_req  (drive_mode_e'(mode_sel)),
      .bank_req  (out_bank),
      .phase_nxt (phase_nxt),
      .mode_nxt  (mode_nxt),
      .bank_nxt  (bank_nxt)
   );

   lcdm_row_map #(
      .ROW_W     (ROW_W),
      .BANK_SWAP (BANK_SWAP)
   ) u_map (
      .phase (phase_nxt),
      .mode  (mode_nxt),
      .bank  (bank_nxt),
      .row   (row_nxt)
   );

   lcdm_col_mux #(
      .NUM_COLS (NUM_COLS),
      .NUM_ROWS (NUM_ROWS)
   ) u_mux (
      .mem_image (mem_image),
      .row       (row_nxt),
      .seg       (seg_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_idx   <= '0;
         bp_onehot <= '0;
         seg_data  <= '0;
      end else if (phase_tick) begin
         row_idx   <= row_nxt;
         bp_onehot <= NUM_ROWS'(1) << phase_nxt;
         seg_data  <= seg_nxt;
      end
   end

endmodule

// File: rtl/lcdm_row_bank_chk.sv
`timescale 1ns/1ps
module lcdm_row_bank_chk #(
   parameter int unsigned NUM_COLS = 40,
   parameter int unsigned NUM_ROWS = 4,
   localparam int unsigned ROW_W   = $clog2(NUM_ROWS),
   localparam int unsigned MEM_W   = NUM_COLS * NUM_ROWS
) (
   input logic                clk,
   input logic                rst_n,
   input logic                phase_tick,
   input logic [MEM_W-1:0]    mem_image,
   input logic [ROW_W-1:0]    row_idx,
   input logic [NUM_ROWS-1:0] bp_onehot,
   input logic [NUM_COLS-1:0] seg_data
);

   function automatic logic [NUM_COLS-1:0] pick_row(input logic [MEM_W-1:0] img,
                                                    input logic [ROW_W-1:0] r);
      return img[r*NUM_COLS +: NUM_COLS];
   endfunction

   AST_BP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bp_onehot));                                              // R10

   AST_TICK_LIGHTS_BP: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |=> ($countones(bp_onehot) == 1));                      // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_tick |=> ($stable(row_idx) && $stable(bp_onehot) && $stable(seg_data))); // R9

   AST_SEG_FROM_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |=> (seg_data == pick_row($past(mem_image), row_idx))); // R8

   AST_PHASE2_ROW2: assert property (@(posedge clk) disable iff (!rst_n)
      bp_onehot[2] |-> (row_idx == 2'd2));                               // R3

   AST_PHASE3_ROW3: assert property (@(posedge clk) disable iff (!rst_n)
      bp_onehot[3] |-> (row_idx == 2'd3));                               // R2

   AST_PHASE1_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      bp_onehot[1] |-> row_idx[0]);                                      // R6

   AST_PHASE0_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      bp_onehot[0] |-> !row_idx[0]);                                     // R6

   AST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_tick && bp_onehot[3]) |=> bp_onehot[0]);                    // R2

   AST_AFTER_PH1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_tick && bp_onehot[1]) |=> (bp_onehot[2] || bp_onehot[0]));  // R4

endmodule

bind lcdm_row_bank_sel lcdm_row_bank_chk #(
   .NUM_COLS (NUM_COLS),
   .NUM_ROWS (NUM_ROWS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase_tick (phase_tick),
   .mem_image  (mem_image),
   .row_idx    (row_idx),
   .bp_onehot  (bp_onehot),
   .seg_data   (seg_data)
);

// File: tb/tb_lcdm_row_bank_sel.sv
`timescale 1ns/1ps
module tb_lcdm_row_bank_sel;

   localparam int NC = 40;
   localparam int NR = 4;
   localparam int NV = 24;

   // {mode[8:7], bank[6], expected row[5:4], expected backplane[3:0]}
   localparam logic [8:0] VEC [NV] = '{
      {2'd3, 1'b0, 2'd0, 4'b0001},   // R1 first tick starts frame, R2
      {2'd3, 1'b0, 2'd1, 4'b0010},   // R2
      {2'd3, 1'b0, 2'd2, 4'b0100},   // R2
      {2'd3, 1'b0, 2'd3, 4'b1000},   // R2
      {2'd2, 1'b0, 2'd0, 4'b0001},   // R7 wrap latches three-phase
      {2'd1, 1'b1, 2'd1, 4'b0010},   // R7 mid-frame change ignored, R3
      {2'd1, 1'b1, 2'd2, 4'b0100},   // R3
      {2'd1, 1'b1, 2'd2, 4'b0001},   // R6 two-phase bank 1 at wrap
      {2'd1, 1'b1, 2'd3, 4'b0010},   // R6 R10
      {2'd1, 1'b0, 2'd0, 4'b0001},   // R4 bank 0 at wrap
      {2'd1, 1'b1, 2'd1, 4'b0010},   // R7 bank change mid-frame ignored
      {2'd0, 1'b1, 2'd2, 4'b0001},   // R6 static bank 1
      {2'd0, 1'b1, 2'd2, 4'b0001},   // R5
      {2'd0, 1'b0, 2'd0, 4'b0001},   // R5 static bank 0
      {2'd3, 1'b1, 2'd0, 4'b0001},   // R6 bank ignored in four-phase
      {2'd3, 1'b1, 2'd1, 4'b0010},   // R2
      {2'd1, 1'b0, 2'd2, 4'b0100},   // R7
      {2'd1, 1'b0, 2'd3, 4'b1000},   // R7
      {2'd1, 1'b0, 2'd0, 4'b0001},   // R4
      {2'd1, 1'b0, 2'd1, 4'b0010},   // R4
      {2'd2, 1'b1, 2'd0, 4'b0001},   // R3 bank ignored in three-phase
      {2'd2, 1'b1, 2'd1, 4'b0010},   // R3
      {2'd2, 1'b1, 2'd2, 4'b0100},   // R3
      {2'd2, 1'b1, 2'd0, 4'b0001}    // R3 wrap after phase 2
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              phase_tick = 1'b0;
   logic [1:0]        mode_sel = 2'd0;
   logic              out_bank = 1'b0;
   logic [NR*NC-1:0]  mem_image = '0;
   logic [1:0]        row_idx;
   logic [NR-1:0]     bp_onehot;
   logic [NC-1:0]     seg_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lcdm_row_bank_sel #(.NUM_COLS(NC), .NUM_ROWS(NR)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_tick (phase_tick),
      .mode_sel   (mode_sel),
      .out_bank   (out_bank),
      .mem_image  (mem_image),
      .row_idx    (row_idx),
      .bp_onehot  (bp_onehot),
      .seg_data   (seg_data)
   );

   function automatic logic [NC-1:0] row_pattern(input int r, input int salt);
      logic [31:0] lo;
      logic [7:0]  hi;
      lo = 32'h9E37_79B9 * 32'(r + salt + 1);
      hi = 8'(8'h2B * (r + 1) + salt);
      return {hi, lo};
   endfunction

   task automatic load_image(input int salt);
      for (int r = 0; r < NR; r++)
         mem_image[r*NC +: NC] = row_pattern(r, salt);
   endtask

   function automatic logic [NC-1:0] exp_seg(input int r);
      return mem_image[r*NC +: NC];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_tick(input logic [1:0] m, input logic b);
      @(negedge clk);
      mode_sel   = m;
      out_bank   = b;
      phase_tick = 1'b1;
      @(negedge clk);
      phase_tick = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      load_image(0);
      mode_sel = 2'd3;
      repeat (3) @(negedge clk);
      check("R1 row", 64'(row_idx), 64'd0);
      check("R1 bp", 64'(bp_onehot), 64'd0);
      check("R1 seg", 64'(seg_data), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after reset", 64'(bp_onehot), 64'd0);

      for (int i = 0; i < NV; i++) begin
         do_tick(VEC[i][8:7], VEC[i][6]);
         check("R6 row", 64'(row_idx), 64'(VEC[i][5:4]));
         check("R10 bp", 64'(bp_onehot), 64'(VEC[i][3:0]));
         check("R8 seg", 64'(seg_data), 64'(exp_seg(int'(VEC[i][5:4]))));
      end

      // R9: image changes without a tick leave outputs frozen
      begin
         logic [NC-1:0] held;
         held = seg_data;
         load_image(7);
         repeat (3) @(negedge clk);
         check("R9 seg hold", 64'(seg_data), 64'(held));
         check("R9 bp hold", 64'(bp_onehot), 64'b0001);
         check("R9 row hold", 64'(row_idx), 64'd0);
      end
      do_tick(2'd2, 1'b1);
      check("R8 seg new image", 64'(seg_data), 64'(exp_seg(1)));
      check("R3 row", 64'(row_idx), 64'd1);

      // R8: image presented in the tick cycle itself is the one captured
      @(negedge clk);
      load_image(3);
      mode_sel   = 2'd2;
      phase_tick = 1'b1;
      @(negedge clk);
      phase_tick = 1'b0;
      check("R8 same-cycle image", 64'(seg_data), 64'(exp_seg(2)));

      // R1: reset mid-frame, then first tick starts a fresh frame
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset bp", 64'(bp_onehot), 64'd0);
      check("R1 mid-run reset seg", 64'(seg_data), 64'd0);
      rst_n = 1'b1;
      do_tick(2'd1, 1'b1);
      check("R1 fresh frame row", 64'(row_idx), 64'd2);
      check("R1 fresh frame bp", 64'(bp_onehot), 64'b0001);
      do_tick(2'd0, 1'b0);
      check("R6 upper pair phase 1", 64'(row_idx), 64'd3);
      check("R8 seg row 3", 64'(seg_data), 64'(exp_seg(3)));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule